// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block derives a card clock from a fast core clock. The core clock runs at twice the reference rate. The card clock is always produced by a register, so both of its levels last a whole number of core cycles. A ratio N sets each level to N core cycles, which gives a card clock period of 2·N core cycles and an exact 50% duty cycle. The supported ratios are 1, 2, 4 and 8.

A host drives a small asynchronous command port: an active-low chip select, an active-low program enable, a mode line, two address lines and a data line. All of these pass through a two-flop synchroniser before any decoding. A command is taken on the low-to-high transition of chip select, and only if program enable was low at that point. A command does one of two things:
- It loads a new ratio.
- It parks the card clock at a chosen level.

Neither kind of command is applied at once. Each waits for a clean boundary of the card clock, so no level is ever cut short. While a command is waiting, a busy output is raised. This tells the host when the clock is settled and a card transaction may start.

Top module: `card_clk_div`

## Requirements
- R1: While reset (rst_n low, synchronous) is held, and after it is released, card_clk is low and busy is low. The block then runs at ratio 1, so card_clk is high for 1 core cycle and low for 1 core cycle.
- R2: A command is accepted only on a rising edge of sel_n, and only if prog_n was low while sel_n was low. A sel_n pulse with prog_n high does not raise busy and does not change the card clock period.
- R3: With mode_sel high, {addr1,addr0} selects the ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. Once applied, card_clk is high for exactly ratio core cycles and low for exactly ratio core cycles.
- R4: A ratio change takes effect only at a falling edge of card_clk. During any change, no card_clk level is shorter than the smaller of the old ratio and the new ratio.
- R5: busy rises within 4 core cycles of the sel_n rise of an accepted command. It falls when the command has been applied, and never later than 40 core cycles after that rise.
- R6: A stop-high command parks card_clk high for as long as no other command arrives. Its encoding is mode_sel low, addr1 low, addr0 low and data_in low.
- R7: A stop-low command parks card_clk low. Its encoding is mode_sel low, addr1 low, addr0 low and data_in high.
- R8: A stop takes effect only after card_clk has spent a full level of the current ratio at the requested value. No shortened level appears before the clock is parked.
- R9: A ratio command issued while the clock is parked restarts the clock at the new ratio.
- R10: A command with mode_sel low and {addr1,addr0} not equal to 00 is ignored. busy stays low and the card clock period does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Core clock, twice the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select; a command is taken on its rising edge |
| prog_n | input | 1 | Active-low program enable |
| mode_sel | input | 1 | High: ratio load; low: stop or reserved |
| addr1 | input | 1 | Ratio code bit 1 |
| addr0 | input | 1 | Ratio code bit 0 |
| data_in | input | 1 | Stop level select: low gives high, high gives low |
| card_clk | output | 1 | Divided card clock, 50% duty cycle |
| busy | output | 1 | A command is accepted but not yet applied |

## Verification
The hardest situation to reach from the ports is a change that lands while the clock is in the opposite phase from the one the change is waiting for. Two cases matter most:
- a slow-to-fast ratio switch requested just after a falling edge;
- a stop-low request made while the clock is parked high, which forces a resume, one full high level and a falling edge before parking.

The bench reaches these by sweeping every ordered pair of ratios, and by issuing stops from each ratio and from the opposite parked level. Throughout the sweep, a monitor tracks the shortest completed card_clk level.

// File: rtl/ccd_pkg.sv
// Shared types and helpers for the card clock divider.
// Assumes that ratios are powers of two and are selected by a CODE_W-bit code.
package ccd_pkg;
    localparam int CODE_W = 2;
    localparam int CNT_W  = (1 << CODE_W) - 1;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_RATIO = 2'd1,
        CMD_STOP  = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [CODE_W-1:0] code;
        logic              lvl;
    } cmd_t;
endpackage

// File: rtl/ccd_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes that each bit is quasi-static and that no bus coherence is needed.
module ccd_sync #(
    parameter int              WIDTH  = 6,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/ccd_decode.sv
// Detects the rising edge of the synchronised chip select and decodes the command.
// The fields are taken from the cycle before the edge, while select was still low.
module ccd_decode
    import ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic prog_s,
    input  logic mode_s,
    input  logic a1_s,
    input  logic a0_s,
    input  logic dat_s,
    output logic cmd_valid,
    output cmd_t cmd
);
    logic sel_d, prog_d, mode_d, a1_d, a0_d, dat_d;

    // Delay select and the fields by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d  <= 1'b1;
            prog_d <= 1'b1;
            mode_d <= 1'b0;
            a1_d   <= 1'b0;
            a0_d   <= 1'b0;
            dat_d  <= 1'b0;
        end else begin
            sel_d  <= sel_s;
            prog_d <= prog_s;
            mode_d <= mode_s;
            a1_d   <= a1_s;
            a0_d   <= a0_s;
            dat_d  <= dat_s;
        end
    end

    // Classify the fields that were held while select was low.
    always_comb begin
        cmd.code = {a1_d, a0_d};
        cmd.lvl  = ~dat_d;
        if (mode_d)
            cmd.kind = CMD_RATIO;
        else if (!a1_d && !a0_d)
            cmd.kind = CMD_STOP;
        else
            cmd.kind = CMD_NONE;
    end

    assign cmd_valid = sel_s && !sel_d && !prog_d && (cmd.kind != CMD_NONE);
endmodule

// File: rtl/ccd_gen.sv
// Card clock generator with a single pending-command slot.
// Each level lasts 2^code core cycles. A ratio change is applied at a falling edge.
// A stop is applied only after a full level at the requested value.
module ccd_gen
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    output logic              card_clk,
    output logic              busy,
    output logic              stopped,
    output logic [CODE_W-1:0] run_code,
    output logic              pend_lvl
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    half;
    logic              clk_q, pend_valid, pend_stop;
    logic [CODE_W-1:0] pend_code;
    logic              tick;

    // Length of one level for the running code.
    always_comb begin
        half = (CNT_W+1)'(1) << run_code;
        tick = ({1'b0, cnt} == half - 1'b1);
    end

    // Advance the divider and apply the pending command at a legal boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            clk_q      <= 1'b0;
            stopped    <= 1'b0;
            run_code   <= '0;
            pend_valid <= 1'b0;
            pend_stop  <= 1'b0;
            pend_lvl   <= 1'b0;
            pend_code  <= '0;
        end else begin
            if (stopped) begin
                if (pend_valid) begin
                    if (!pend_stop) begin
                        run_code   <= pend_code;
                        stopped    <= 1'b0;
                        cnt        <= '0;
                        pend_valid <= 1'b0;
                    end else if (pend_lvl == clk_q) begin
                        pend_valid <= 1'b0;
                    end else begin
                        stopped <= 1'b0;
                        cnt     <= '0;
                    end
                end
            end else if (tick) begin
                cnt <= '0;
                if (pend_valid && pend_stop && (clk_q == pend_lvl)) begin
                    stopped    <= 1'b1;
                    pend_valid <= 1'b0;
                end else begin
                    clk_q <= ~clk_q;
                    if (pend_valid && !pend_stop && clk_q) begin
                        run_code   <= pend_code;
                        pend_valid <= 1'b0;
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (cmd_valid) begin
                pend_valid <= 1'b1;
                pend_stop  <= (cmd.kind == CMD_STOP);
                pend_lvl   <= cmd.lvl;
                pend_code  <= cmd.code;
            end
        end
    end

    assign card_clk = clk_q;
    assign busy     = pend_valid;
endmodule

// File: rtl/card_clk_div.sv
// Top of the programmable card clock divider.
// The command pins are asynchronous to clk_in. The reset is synchronous and active low.
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel_n,
    input  logic prog_n,
    input  logic mode_sel,
    input  logic addr1,
    input  logic addr0,
    input  logic data_in,
    output logic card_clk,
    output logic busy
);
    localparam int PINS = 6;
    localparam logic [PINS-1:0] PIN_IDLE = 6'b110000;

    logic [PINS-1:0]   pins_s;
    logic              cmd_valid, stopped, pend_lvl;
    logic [CODE_W-1:0] run_code;
    cmd_t              cmd;

    ccd_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d_in  ({sel_n, prog_n, mode_sel, addr1, addr0, data_in}),
        .q_out (pins_s)
    );

    ccd_decode u_dec (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .sel_s     (pins_s[5]),
        .prog_s    (pins_s[4]),
        .mode_s    (pins_s[3]),
        .a1_s      (pins_s[2]),
        .a0_s      (pins_s[1]),
        .dat_s     (pins_s[0]),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    ccd_gen u_gen (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .card_clk  (card_clk),
        .busy      (busy),
        .stopped   (stopped),
        .run_code  (run_code),
        .pend_lvl  (pend_lvl)
    );
endmodule

// File: rtl/ccd_checker.sv
// Property checker for card_clk_div; it is attached to the top through bind.
module ccd_checker
    import ccd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              card_clk,
    input logic              busy,
    input logic              cmd_valid,
    input logic              stopped,
    input logic [CODE_W-1:0] run_code,
    input logic              pend_lvl
);
    logic              prev_clk;
    logic [3:0]        held;
    logic [CODE_W-1:0] code_prev;

    // Track how long card_clk has held its level and which code was running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_clk  <= 1'b0;
            held      <= 4'd1;
            code_prev <= '0;
        end else begin
            prev_clk  <= card_clk;
            code_prev <= run_code;
            if (card_clk != prev_clk) held <= 4'd1;
            else if (held != 4'd15)   held <= held + 1'b1;
        end
    end

    a_r5_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> busy);

    a_r6_parked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && $past(stopped)) |-> $stable(card_clk));

    a_r8_park_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> (card_clk == $past(pend_lvl)));

    a_r4_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk != prev_clk) |-> (held >= (4'd1 << code_prev)));
endmodule

bind card_clk_div ccd_checker u_chk (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .card_clk  (card_clk),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .stopped   (stopped),
    .run_code  (run_code),
    .pend_lvl  (pend_lvl)
);

// File: tb/tb_card_clk_div.sv
// Sweep bench for card_clk_div: all ratio pairs, stops from every ratio, ignored commands.
module tb_card_clk_div;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, prog_n = 1'b1, mode_sel = 1'b0;
    logic addr1 = 1'b0, addr0 = 1'b0, data_in = 1'b0;
    logic card_clk, busy;

    int checks = 0, errors = 0;
    int cur_len = 0, min_len = 1000;
    logic last_clk = 1'b0;

    always #5 clk = ~clk;

    card_clk_div dut (
        .clk_in(clk), .rst_n(rst_n), .sel_n(sel_n), .prog_n(prog_n),
        .mode_sel(mode_sel), .addr1(addr1), .addr0(addr0), .data_in(data_in),
        .card_clk(card_clk), .busy(busy)
    );

    // Level-length monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cur_len  <= 0;
            last_clk <= card_clk;
        end else if (card_clk != last_clk) begin
            if (cur_len < min_len) min_len <= cur_len;
            cur_len  <= 1;
            last_clk <= card_clk;
        end else begin
            cur_len <= cur_len + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one command; report whether busy rose in time and how long until it fell.
    task automatic send(input logic p, input logic m, input logic b1, input logic b0,
                        input logic d, output int rise_at, output int fall_at);
        @(negedge clk);
        prog_n = p; mode_sel = m; addr1 = b1; addr0 = b0; data_in = d; sel_n = 1'b0;
        cyc(4);
        sel_n = 1'b1;
        rise_at = -1; fall_at = -1;
        for (int i = 1; i <= 45; i++) begin
            @(negedge clk);
            if (busy && rise_at < 0) rise_at = i;
            if (!busy && rise_at >= 0 && fall_at < 0) fall_at = i;
        end
        prog_n = 1'b1;
    endtask

    // Measure one high level and the low level that follows it.
    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int i = 0; i < 40 && card_clk; i++) @(negedge clk);
        for (int i = 0; i < 40 && !card_clk; i++) @(negedge clk);
        for (int i = 0; i < 40 && card_clk; i++) begin hi++; @(negedge clk); end
        for (int i = 0; i < 40 && !card_clk; i++) begin lo++; @(negedge clk); end
    endtask

    task automatic set_ratio(input int code, output int r, output int f);
        send(1'b0, 1'b1, code[1], code[0], 1'b0, r, f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, r, f, chg;
        cyc(3);
        check("R1 reset card_clk", card_clk, 0);
        check("R1 reset busy", busy, 0);
        @(negedge clk) rst_n = 1'b1;
        check("R1 busy after reset", busy, 0);
        measure(hi, lo);
        check("R1 default high", hi, 1);
        check("R1 default low", lo, 1);

        // R3 and R4: every ordered pair of ratios.
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                set_ratio(o, r, f);
                cyc(4);
                min_len = 1000;
                set_ratio(n, r, f);
                check("R5 busy rise", (r >= 1 && r <= 4) ? 1 : 0, 1);
                check("R5 busy fall", (f > 0 && f <= 40) ? 1 : 0, 1);
                measure(hi, lo);
                check("R3 high level", hi, 1 << n);
                check("R3 low level", lo, 1 << n);
                check("R4 no runt", (min_len >= (1 << ((o < n) ? o : n))) ? 1 : 0, 1);
            end
        end

        // R6, R7, R8, R9: stop at each level from each ratio, then resume.
        for (int c = 0; c < 4; c++) begin
            for (int lv = 0; lv < 2; lv++) begin
                set_ratio(c, r, f);
                cyc(4);
                min_len = 1000;
                send(1'b0, 1'b0, 1'b0, 1'b0, lv[0], r, f);
                check(lv ? "R7 stop low level" : "R6 stop high level", card_clk, lv ? 0 : 1);
                check("R8 full level before park", (min_len >= (1 << c)) ? 1 : 0, 1);
                chg = 0;
                for (int i = 0; i < 30; i++) begin
                    @(negedge clk);
                    if (card_clk != (lv ? 1'b0 : 1'b1)) chg++;
                end
                check(lv ? "R7 parked low" : "R6 parked high", chg, 0);
                // Opposite stop while parked: resume, one full level, then park.
                send(1'b0, 1'b0, 1'b0, 1'b0, ~lv[0], r, f);
                check("R8 repark opposite", card_clk, lv ? 1 : 0);
                check("R5 repark busy done", (f > 0) ? 1 : 0, 1);
                set_ratio((c + 1) % 4, r, f);
                measure(hi, lo);
                check("R9 restart high", hi, 1 << ((c + 1) % 4));
                check("R9 restart low", lo, 1 << ((c + 1) % 4));
            end
        end

        // R2 and R10: ignored commands leave busy low and the period unchanged.
        set_ratio(1, r, f);
        for (int k = 1; k < 4; k++) begin
            send(1'b0, 1'b0, k[1], k[0], 1'b0, r, f);
            check("R10 reserved no busy", r, -1);
            measure(hi, lo);
            check("R10 period kept", hi + lo, 4);
        end
        send(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, r, f);
        check("R2 prog high no busy", r, -1);
        measure(hi, lo);
        check("R2 period kept", hi + lo, 4);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, r, f);
        check("R2 prog high stop ignored", r, -1);
        measure(hi, lo);
        check("R2 still running", hi + lo, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule